// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The host raises a request with a direction flag, an address and write data, and holds them until the block answers with a one-cycle `ready`. The block then plays out a sequence of memory control levels whose phases are counted in clock cycles. The memory has an active-low chip enable, an active-high chip enable, an active-low output enable and an active-low write strobe. The data bus is split into an outgoing value, an incoming value and a drive enable.

Writes pass through address setup, the strobe, recovery and a completion cycle. Reads hold the output enable low for the access count and then register the returned byte. A build option keeps the output enable low through the write's setup and strobe. In that case the strobe is lengthened so the memory can release the bus and the block can still meet data setup. Between requests the memory is deselected, so it rests in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and on every idle cycle between requests, mem_ce1_n is 1, mem_ce2 is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and ready is 0.
- R2: The two chip enables always switch together: mem_ce1_n equals the inverse of mem_ce2 in every cycle.
- R3: A write holds mem_we_n high with the memory selected for T_SETUP cycles. It then drives mem_we_n low only while the memory is selected, and keeps the data driven and the memory selected for T_RECOV cycles after mem_we_n returns high.
- R4: mem_addr is loaded from addr when a request is accepted and never changes in a cycle where mem_we_n is low.
- R5: mem_dq_oe is never 1 while the memory may drive the bus. That covers every cycle where mem_oe_n is low and mem_we_n is high, and, when KEEP_OE is 1, the first T_OFF cycles of the strobe.
- R6: The strobe lasts exactly T_PULSE cycles when KEEP_OE is 0. When KEEP_OE is 1 it lasts the larger of T_PULSE and T_OFF+T_DSU+1. In both cases the write data is driven for at least T_DSU strobe cycles before mem_we_n rises.
- R7: ready is a single-cycle pulse. For a write it is high in cycle T_SETUP+strobe+T_RECOV+1, counted from the clock edge that accepts the request.
- R8: A read keeps mem_oe_n low for T_ACCESS cycles and registers mem_din on the edge that ends them. ready and the new rdata appear in cycle T_ACCESS+1 after the accepting edge, and rdata holds until the next read completes.
- R9: Requests are accepted only when idle. Changes to we, addr and wdata while busy do not alter the operation in progress, and each write commits exactly once.
- R10: A completed write stores wdata at the accepted address, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write byte |
| rdata | output | DW | Last byte read |
| ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data driven toward the memory |
| mem_din | input | DW | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dout |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The memory model in the bench returns a garbage byte until the output enable has been low for the full access count. A design that captured one edge early would therefore return the wrong byte. The model lets go of the bus only T_OFF strobe cycles after the strobe falls, so a write that drove data too soon shows up as contention. A strobe left unstretched fails the minimum-width rule, as does data that arrives too late for setup. During busy cycles the bench scrambles we, addr and wdata. A design that sampled them late would write to the wrong address, commit twice or finish at the wrong time.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE,
        ST_ACCESS,
        ST_CAPTURE
    } state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int T_SETUP  = 1,
    parameter int T_PULSE  = 2,
    parameter int T_RECOV  = 1,
    parameter int T_ACCESS = 7,
    parameter int T_OFF    = 2,
    parameter int T_DSU    = 1,
    parameter bit KEEP_OE  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic accept,
    output logic capture,
    output logic ready,
    output logic sel,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);

    localparam int STRETCH   = T_OFF + T_DSU + 1;
    localparam int PULSE_CYC = KEEP_OE ? imax(T_PULSE, STRETCH) : T_PULSE;
    localparam int MAXC      = imax(imax(T_SETUP, PULSE_CYC), imax(T_RECOV, T_ACCESS));
    localparam int CW        = $clog2(MAXC + 1);
    localparam int DRV_FROM  = KEEP_OE ? T_OFF : 0;

    localparam logic [CW-1:0] LD_SETUP  = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] LD_PULSE  = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_RECOV  = CW'(T_RECOV - 1);
    localparam logic [CW-1:0] LD_ACCESS = CW'(T_ACCESS - 1);
    localparam logic [CW-1:0] DRV_LAST  = CW'(PULSE_CYC - 1 - DRV_FROM);

    typedef struct packed {
        state_t          st;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (we) begin
                        d.st  = ST_SETUP;
                        d.cnt = LD_SETUP;
                    end else begin
                        d.st  = ST_ACCESS;
                        d.cnt = LD_ACCESS;
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_STROBE;
                    d.cnt = LD_PULSE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (q.cnt == '0) begin
                    d.st  = ST_RECOVER;
                    d.cnt = LD_RECOV;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (q.cnt == '0) d.st = ST_DONE;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_ACCESS: begin
                if (q.cnt == '0) begin
                    capture = 1'b1;
                    d.st    = ST_CAPTURE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sel   = (q.st == ST_SETUP) || (q.st == ST_STROBE) ||
                (q.st == ST_RECOVER) || (q.st == ST_ACCESS);
        we_n  = (q.st != ST_STROBE);
        oe_n  = !((q.st == ST_ACCESS) ||
                  (KEEP_OE && ((q.st == ST_SETUP) || (q.st == ST_STROBE))));
        dq_oe = ((q.st == ST_STROBE) && (q.cnt <= DRV_LAST)) ||
                (q.st == ST_RECOVER) ||
                (!KEEP_OE && (q.st == ST_SETUP));
        ready = (q.st == ST_DONE) || (q.st == ST_CAPTURE);
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdat;
    } dp_t;

    dp_t q, d;

    always_comb begin
        d = q;
        if (accept) begin
            d.addr = addr;
            d.wdat = wdata;
        end
        if (capture) d.rdat = mem_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr = q.addr;
    assign mem_dout = q.wdat;
    assign rdata    = q.rdat;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int T_SETUP  = 1,
    parameter int T_PULSE  = 2,
    parameter int T_RECOV  = 1,
    parameter int T_ACCESS = 7,
    parameter int T_OFF    = 2,
    parameter int T_DSU    = 1,
    parameter bit KEEP_OE  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_dq_oe,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n
);

    logic accept, capture, sel;

    sram_ctrl_seq #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_RECOV (T_RECOV),
        .T_ACCESS(T_ACCESS),
        .T_OFF   (T_OFF),
        .T_DSU   (T_DSU),
        .KEEP_OE (KEEP_OE)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .we     (we),
        .accept (accept),
        .capture(capture),
        .ready  (ready),
        .sel    (sel),
        .oe_n   (mem_oe_n),
        .we_n   (mem_we_n),
        .dq_oe  (mem_dq_oe)
    );

    sram_ctrl_dpath #(
        .AW(AW),
        .DW(DW)
    ) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .capture (capture),
        .addr    (addr),
        .wdata   (wdata),
        .mem_din (mem_din),
        .mem_addr(mem_addr),
        .mem_dout(mem_dout),
        .rdata   (rdata)
    );

    assign mem_ce1_n = !sel;
    assign mem_ce2   = sel;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int T_PULSE = 2,
    parameter int T_OFF   = 2,
    parameter int T_DSU   = 1,
    parameter bit KEEP_OE = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic [DW-1:0] rdata,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_oe_n,
    input logic          mem_we_n
);

    localparam int        PMIN_I = KEEP_OE ? imax(T_PULSE, T_OFF + T_DSU + 1) : T_PULSE;
    localparam logic [7:0] PMIN  = 8'(PMIN_I);
    localparam logic [7:0] OFFC  = KEEP_OE ? 8'(T_OFF) : 8'd0;
    localparam logic [7:0] DSUC  = 8'(T_DSU);

    // cycles of strobe already elapsed, and strobe cycles with data driven
    logic [7:0] low_q, drv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
            drv_q <= '0;
        end else begin
            low_q <= mem_we_n ? 8'd0 : ((low_q == 8'hFF) ? low_q : low_q + 8'd1);
            drv_q <= (!mem_we_n && mem_dq_oe) ? ((drv_q == 8'hFF) ? drv_q : drv_q + 8'd1) : 8'd0;
        end
    end

    p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_ce_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);

    p_we_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_addr));

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n || (!mem_we_n && low_q >= OFFC)));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (low_q >= PMIN));

    p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (drv_q >= DSUC));

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> ready);

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .AW     (AW),
    .DW     (DW),
    .T_PULSE(T_PULSE),
    .T_OFF  (T_OFF),
    .T_DSU  (T_DSU),
    .KEEP_OE(KEEP_OE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rdata    (rdata),
    .mem_addr (mem_addr),
    .mem_dq_oe(mem_dq_oe),
    .mem_ce1_n(mem_ce1_n),
    .mem_ce2  (mem_ce2),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

    localparam int T_SETUP  = 1;
    localparam int T_PULSE  = 2;
    localparam int T_RECOV  = 1;
    localparam int T_ACCESS = 7;
    localparam int T_OFF    = 2;
    localparam int T_DSU    = 1;
    localparam int PULSE_MIN = (T_PULSE > T_OFF + T_DSU + 1) ? T_PULSE : T_OFF + T_DSU + 1;
    localparam int WR_LAT   = T_SETUP + PULSE_MIN + T_RECOV + 1;
    localparam int RD_LAT   = T_ACCESS + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;
    logic        mem_dq_oe, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;

    always #2.5 clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    int vecs = 0;
    int errs = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    // behavioural memory and scoreboard
    logic [7:0] mem [int];
    logic [7:0] sb  [int];
    int wl = 0, dl = 0, oel = 0, nwrites = 0;
    logic        prev_we_n = 1'b1;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dout = '0;
    logic        sel_m, mdrv;

    always @(*) begin
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n && oel >= T_ACCESS)
            mem_din = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h3C;
        else
            mem_din = 8'h5A;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            wl = 0; dl = 0; oel = 0;
            prev_we_n = 1'b1;
            prev_addr = mem_addr;
        end else begin
            sel_m = !mem_ce1_n && mem_ce2;
            chk(mem_ce1_n == !mem_ce2, "R2 enables paired", int'(mem_ce1_n), int'(!mem_ce2));
            if (!mem_we_n) begin
                chk(sel_m, "R3 strobe while selected", int'(sel_m), 1);
                chk(mem_addr == prev_addr, "R4 address held in strobe", int'(mem_addr), int'(prev_addr));
            end
            mdrv = sel_m && !mem_oe_n && (mem_we_n || wl < T_OFF);
            chk(!(mdrv && mem_dq_oe), "R5 bus contention", int'(mem_dq_oe), 0);
            if (mem_we_n && !prev_we_n) begin
                chk(wl >= PULSE_MIN, "R6 strobe width", wl, PULSE_MIN);
                chk(dl >= T_DSU, "R6 data setup", dl, T_DSU);
                mem[int'(prev_addr)] = prev_dout;
                nwrites++;
            end
            wl  = mem_we_n ? 0 : wl + 1;
            dl  = (!mem_we_n && mem_dq_oe) ? dl + 1 : 0;
            oel = (sel_m && !mem_oe_n) ? oel + 1 : 0;
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
            prev_dout = mem_dout;
        end
    end

    task automatic idle_check(input string tag);
        chk(mem_ce1_n && !mem_ce2, {"R1 standby enables ", tag}, int'({mem_ce1_n, mem_ce2}), 2);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe && !ready, {"R1 idle controls ", tag},
            int'({mem_we_n, mem_oe_n, mem_dq_oe, ready}), 12);
    endtask

    task automatic run_op(input bit w, input logic [16:0] a, input logic [7:0] dv, input bit scramble);
        int lat = w ? WR_LAT : RD_LAT;
        int nw0 = nwrites;
        int lows = 0, first_low = 0, oe_lows = 0;
        req = 1'b1; we = w; addr = a; wdata = dv;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (!mem_we_n) begin
                lows++;
                if (first_low == 0) first_low = k;
            end
            if (!mem_oe_n && !w) oe_lows++;
            chk(ready == (k == lat), w ? "R7 write ready timing" : "R8 read ready timing",
                int'(ready), int'(k == lat));
            if (scramble && k == 1) begin
                we = !w; addr = ~a; wdata = ~dv;   // R9: must not matter
            end
        end
        if (w) begin
            chk(first_low == T_SETUP + 1, "R3 address setup before strobe", first_low, T_SETUP + 1);
            chk(lows == PULSE_MIN, "R6 stretched strobe length", lows, PULSE_MIN);
        end else begin
            chk(oe_lows == T_ACCESS, "R8 output enable window", oe_lows, T_ACCESS);
            chk(rdata == sb[int'(a)], "R10 read returns written byte", int'(rdata), int'(sb[int'(a)]));
        end
        req = 1'b0;
        @(negedge clk);
        idle_check("between requests");
        if (w) begin
            sb[int'(a)] = dv;
            chk(nwrites == nw0 + 1, "R9 single commit per write", nwrites - nw0, 1);
            chk(mem.exists(int'(a)) && mem[int'(a)] == dv, "R10 byte stored at accepted address",
                mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, int'(dv));
            if (scramble)
                chk(!mem.exists(int'(~a)), "R9 busy inputs ignored", int'(mem.exists(int'(~a))), 0);
        end else begin
            chk(nwrites == nw0, "R9 read commits nothing", nwrites - nw0, 0);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vecs++;
            errs++;
            $display("FAIL watchdog R7/R8 completion: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        chk(rdata == 8'h00 && mem_addr == '0, "R1 reset data regs", int'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("after reset");

        run_op(1'b1, 17'h00000, 8'h00, 1'b0);
        run_op(1'b1, 17'h1FFFF, 8'hFF, 1'b0);
        run_op(1'b1, 17'h12345, 8'hA5, 1'b0);
        run_op(1'b0, 17'h00000, 8'h00, 1'b0);
        run_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);
        run_op(1'b0, 17'h12345, 8'h00, 1'b0);

        // R8: rdata holds through a write
        held = rdata;
        run_op(1'b1, 17'h00F0F, 8'h96, 1'b1);
        chk(rdata == held, "R8 rdata held across write", int'(rdata), int'(held));
        run_op(1'b0, 17'h00F0F, 8'h00, 1'b1);

        run_op(1'b1, 17'h12345, 8'h5A, 1'b0);
        run_op(1'b0, 17'h12345, 8'h00, 1'b0);

        for (int i = 0; i < 12; i++)
            run_op(1'b1, 17'(i * 4099 + 7), 8'(i * 37 + 3), 1'b0);
        for (int i = 11; i >= 0; i--)
            run_op(1'b0, 17'(i * 4099 + 7), 8'h00, 1'b0);

        repeat (3) @(negedge clk);
        idle_check("long idle");
        summary();
        $finish;
    end

endmodule